// File: doc/BRIEF.md
# E1 CRC-4 Sub-Multiframe Checker

This receive-side block verifies each half of an E1 CRC-4 multiframe. An upstream alignment block supplies the serial line bits, one per accepted bit, with a frame index from 0 to 15 and the bit position inside the frame. The checker runs a CRC-4 over every bit of an 8-frame sub-multiframe. Frames 0 to 7 make up the first half and frames 8 to 15 the second. It then compares the result with the four check bits carried by the next sub-multiframe. A mismatch gives a one-cycle local block-error pulse.

The same stream carries the far-end reports. These are the first timeslot-0 bit of frames 13 and 15. A report bit received as 0 gives a one-cycle far-end error pulse. Both kinds of error feed saturating counters. Checking is held off while the alignment block reports that multiframe alignment is not valid. A comparison is made only when the sub-multiframe that produced the reference CRC was received entirely under valid alignment.

Top module: `e1crc_smf_checker`

## Requirements
- R1: When reset is released, `blockErr` and `farErr` are 0 and both counters are 0.
- R2: The checksum of a sub-multiframe uses the generator x^4 + x + 1, fed most significant bit first. The register is zero at bit position 0 of frame 0 or frame 8. Every accepted bit of frames 0–7 (or 8–15) is included, except that the check-bit positions are taken as 0.
- R3: The check bits sit at bit position 0 of the even frames. The received value is C1..C4, with C1 from frame 0/8 as the most significant bit and C4 from frame 6/14 as the least. When the value differs from the checksum of the preceding sub-multiframe, `blockErr` is 1 for exactly the cycle after the C4 bit is accepted.
- R4: When the received check value equals that checksum, `blockErr` stays 0.
- R5: Bit position 0 of frames 13 and 15 are far-end report bits. A report bit accepted as 0 makes `farErr` 1 for exactly the next cycle. A report bit of 1 leaves it 0. Bit position 0 of other odd frames never raises it.
- R6: `localErrCnt` increases by one for each `blockErr` pulse. It holds at its all-ones value (CNT_W bits, 16 by default).
- R7: `farErrCnt` increases by one for each `farErr` pulse. It holds at all ones.
- R8: While `mfAligned` is 0, no pulse is produced. A comparison is made only when `mfAligned` stayed 1 from the start of the preceding sub-multiframe up to and including the C4 bit.
- R9: Cycles with `bitValid` at 0 have no effect on the checksum, the collected check bits, the pulses or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Qualifies `rxBit`, `frameIdx`, `bitPos` this cycle |
| rxBit | input | 1 | Received line bit |
| frameIdx | input | 4 | Frame number in the multiframe, 0–15 |
| bitPos | input | $clog2(BITS_PER_FRAME) | Bit position in the frame, 0 is the first timeslot-0 bit |
| mfAligned | input | 1 | Multiframe alignment valid |
| blockErr | output | 1 | Local CRC mismatch pulse |
| farErr | output | 1 | Far-end block error pulse |
| localErrCnt | output | CNT_W | Saturating count of local block errors |
| farErrCnt | output | CNT_W | Saturating count of far-end errors |

## Verification
The main function is driven with payloads that are random, all zeros, all ones and alternating. Each carries check bits that are either correct or corrupted in chosen bit positions. All-zero data tells a register that was not cleared apart from one that was. Single-bit corruption of C1 and of C4 shows the MSB-first ordering. Random payloads with random idle gaps catch any polynomial or feed-order slip, and show that idle cycles leave the state alone. Alignment is dropped for whole sub-multiframes and in the middle of one. This separates the suppression of the current comparison from the loss of the next reference. The report bits are swept over both values in frames 13 and 15. A long run of mismatches drives both counters to their limit.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;
  localparam int CRC_W   = 4;
  localparam int FIDX_W  = 4;
  localparam logic [CRC_W-1:0] GEN_LOW = 4'b0011;

  typedef struct packed {
    logic shift;
    logic smfStart;
    logic smfEnd;
    logic zeroBit;
    logic cLoad;
    logic cmpEn;
    logic farEn;
  } strobeT;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur, input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
  endfunction
endpackage

// File: rtl/e1crc_ctrl.sv
module e1crc_ctrl
  import e1crc_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic [FIDX_W-1:0] frameIdx,
  input  logic [POS_W-1:0]  bitPos,
  input  logic              mfAligned,
  output strobeT            stb
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BITS_PER_FRAME - 1);

  logic atSi, evenFrame, reportFrame;
  logic runOk, prevOk;

  assign atSi        = bitValid && (bitPos == '0);
  assign evenFrame   = !frameIdx[0];
  assign reportFrame = (frameIdx == 4'd13) || (frameIdx == 4'd15);

  always_comb begin
    stb          = '0;
    stb.shift    = bitValid;
    stb.smfStart = atSi && (frameIdx[2:0] == 3'd0);
    stb.smfEnd   = bitValid && (frameIdx[2:0] == 3'd7) && (bitPos == LAST_POS);
    stb.zeroBit  = atSi && evenFrame;
    stb.cLoad    = atSi && evenFrame;
    stb.cmpEn    = atSi && evenFrame && (frameIdx[2:1] == 2'd3) && prevOk && mfAligned;
    stb.farEn    = atSi && reportFrame && mfAligned;
  end

  // runOk: current sub-multiframe seen from its start under alignment
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runOk  <= 1'b0;
      prevOk <= 1'b0;
    end else if (!mfAligned) begin
      runOk  <= 1'b0;
      prevOk <= 1'b0;
    end else begin
      if (stb.smfStart) runOk <= 1'b1;
      if (stb.smfEnd)   prevOk <= runOk;
    end
  end

  // R8
  prev_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN) prevOk |-> runOk);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.smfEnd, stb.cLoad, stb.farEn}));
endmodule

// File: rtl/e1crc_datapath.sv
module e1crc_datapath
  import e1crc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  strobeT           stb,
  output logic             blockErr,
  output logic             farErr,
  output logic [CNT_W-1:0] localErrCnt,
  output logic [CNT_W-1:0] farErrCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             din;
  logic [CRC_W-1:0] crcReg, crcNext, prevCrc, cReg, cWord;

  assign din     = stb.zeroBit ? 1'b0 : rxBit;
  assign crcNext = crcStep(stb.smfStart ? '0 : crcReg, din);
  assign cWord   = {cReg[CRC_W-2:0], rxBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '0;
      prevCrc <= '0;
      cReg    <= '0;
    end else begin
      if (stb.shift)  crcReg  <= crcNext;
      if (stb.smfEnd) prevCrc <= crcNext;
      if (stb.cLoad)  cReg    <= cWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockErr    <= 1'b0;
      farErr      <= 1'b0;
      localErrCnt <= '0;
      farErrCnt   <= '0;
    end else begin
      blockErr <= stb.cmpEn && (cWord != prevCrc);
      farErr   <= stb.farEn && !rxBit;
      if (stb.cmpEn && (cWord != prevCrc) && (localErrCnt != CNT_MAX))
        localErrCnt <= localErrCnt + CNT_W'(1);
      if (stb.farEn && !rxBit && (farErrCnt != CNT_MAX))
        farErrCnt <= farErrCnt + CNT_W'(1);
    end
  end

  // R6
  local_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (localErrCnt != $past(localErrCnt)) |-> (blockErr && localErrCnt == $past(localErrCnt) + CNT_W'(1)));
  // R6
  local_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(localErrCnt) == CNT_MAX) |-> (localErrCnt == CNT_MAX));
  // R7
  far_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (farErrCnt != $past(farErrCnt)) |-> (farErr && farErrCnt == $past(farErrCnt) + CNT_W'(1)));
endmodule

// File: rtl/e1crc_smf_checker.sv
module e1crc_smf_checker
  import e1crc_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int CNT_W          = 16,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              rxBit,
  input  logic [FIDX_W-1:0] frameIdx,
  input  logic [POS_W-1:0]  bitPos,
  input  logic              mfAligned,
  output logic              blockErr,
  output logic              farErr,
  output logic [CNT_W-1:0]  localErrCnt,
  output logic [CNT_W-1:0]  farErrCnt
);
  strobeT stb;

  e1crc_ctrl #(.BITS_PER_FRAME(BITS_PER_FRAME)) ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameIdx(frameIdx),
    .bitPos(bitPos), .mfAligned(mfAligned), .stb(stb)
  );

  e1crc_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .stb(stb),
    .blockErr(blockErr), .farErr(farErr),
    .localErrCnt(localErrCnt), .farErrCnt(farErrCnt)
  );

  // R9
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitValid) |-> (!blockErr && !farErr));
  // R5
  far_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    farErr |-> (($past(frameIdx) == 4'd13 || $past(frameIdx) == 4'd15) && $past(bitPos) == '0));
  // R8
  aligned_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockErr || farErr) |-> $past(mfAligned));
endmodule

// File: tb/e1crc_smf_checker_test.sv
`timescale 1ns/1ps
module e1crc_smf_checker_test;
  localparam int BPF   = 32;
  localparam int CNT_W = 4;
  localparam int SMFB  = 8 * BPF;
  localparam int POS_W = $clog2(BPF);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rstN = 1'b0, bitValid = 1'b0, rxBit = 1'b0, mfAligned = 1'b0;
  logic [3:0] frameIdx = '0;
  logic [POS_W-1:0] bitPos = '0;
  logic blockErr, farErr;
  logic [CNT_W-1:0] localErrCnt, farErrCnt;

  e1crc_smf_checker #(.BITS_PER_FRAME(BPF), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit), .frameIdx(frameIdx),
    .bitPos(bitPos), .mfAligned(mfAligned), .blockErr(blockErr), .farErr(farErr),
    .localErrCnt(localErrCnt), .farErrCnt(farErrCnt)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit doneFlag = 0;
  logic alignReq = 1'b0;
  bit runOkM = 0, prevOkM = 0;
  logic [3:0] prevCrcM = '0, lastCrc = '0, pendCrc = '0, cAccM = '0;
  int locM = 0, farM = 0, half = 0;
  logic payload[SMFB];
  logic divWork[SMFB+4];

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // polynomial long division of the zero-filled message times x^4 by 10011
  function automatic logic [3:0] refCrc();
    for (int i = 0; i < SMFB; i++)
      divWork[i] = ((i % BPF == 0) && ((i / BPF) % 2 == 0)) ? 1'b0 : payload[i];
    for (int i = 0; i < 4; i++) divWork[SMFB+i] = 1'b0;
    for (int i = 0; i < SMFB; i++)
      if (divWork[i]) begin
        divWork[i]   = ~divWork[i];
        divWork[i+3] = ~divWork[i+3];
        divWork[i+4] = ~divWork[i+4];
      end
    return {divWork[SMFB], divWork[SMFB+1], divWork[SMFB+2], divWork[SMFB+3]};
  endfunction

  task automatic checkCounters(string tag);
    check({tag, " R6 localErrCnt"}, int'(localErrCnt), locM);
    check({tag, " R7 farErrCnt"}, int'(farErrCnt), farM);
  endtask

  task automatic gapCycle();
    @(negedge clk);
    bitValid = 1'b0; rxBit = 1'($urandom); frameIdx = 4'($urandom); bitPos = POS_W'($urandom);
    mfAligned = alignReq;
    @(posedge clk);
    if (!mfAligned) begin runOkM = 0; prevOkM = 0; end
    #1;
    check("R9 blockErr idle", int'(blockErr), 0);
    check("R9 farErr idle", int'(farErr), 0);
    checkCounters("R9");
  endtask

  task automatic sendBit(int fr, int pos, logic b, int gapPct);
    int fr8;
    bit isC, expBlk, expFar, cmpSlot;
    while (int'($urandom % 100) < gapPct) gapCycle();
    @(negedge clk);
    bitValid = 1'b1; rxBit = b; frameIdx = 4'(fr); bitPos = POS_W'(pos); mfAligned = alignReq;
    fr8 = fr % 8;
    isC = (pos == 0) && (fr % 2 == 0);
    if (isC) cAccM = {cAccM[2:0], b};
    cmpSlot = isC && (fr8 == 6);
    expBlk = cmpSlot && prevOkM && mfAligned && (cAccM != prevCrcM);
    expFar = (pos == 0) && (fr == 13 || fr == 15) && mfAligned && !b;
    if (!mfAligned) begin runOkM = 0; prevOkM = 0; end
    else begin
      if (fr8 == 0 && pos == 0) runOkM = 1;
      if (fr8 == 7 && pos == BPF - 1) prevOkM = runOkM;
    end
    if (fr8 == 7 && pos == BPF - 1) prevCrcM = pendCrc;
    if (expBlk && locM < CMAX) locM++;
    if (expFar && farM < CMAX) farM++;
    @(posedge clk); #1;
    if (cmpSlot) check(expBlk ? "R3 blockErr mismatch" : "R4/R8 blockErr quiet", int'(blockErr), int'(expBlk));
    else check("R3 blockErr outside C4 slot", int'(blockErr), 0);
    check("R5 farErr", int'(farErr), int'(expFar));
    checkCounters("R2");
  endtask

  // pat: 0 random, 1 zeros, 2 ones, 3 alternating
  task automatic runSmf(int pat, logic [3:0] corrupt, logic e13, logic e15, int dropAt, int gapPct);
    int base;
    logic [3:0] sendC;
    base = half ? 8 : 0;
    for (int i = 0; i < SMFB; i++)
      case (pat)
        1: payload[i] = 1'b0;
        2: payload[i] = 1'b1;
        3: payload[i] = 1'(i % 2);
        default: payload[i] = 1'($urandom);
      endcase
    sendC = lastCrc ^ corrupt;
    for (int k = 0; k < 4; k++) payload[2*k*BPF] = sendC[3-k];
    if (half != 0) begin payload[5*BPF] = e13; payload[7*BPF] = e15; end
    pendCrc = refCrc();
    for (int i = 0; i < SMFB; i++) begin
      if (i == dropAt) alignReq = 1'b0;
      if (dropAt >= 0 && i == dropAt + 6) alignReq = 1'b1;
      sendBit(base + i / BPF, i % BPF, payload[i], gapPct);
    end
    lastCrc = pendCrc;
    half ^= 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 blockErr reset", int'(blockErr), 0);
    check("R1 farErr reset", int'(farErr), 0);
    check("R1 localErrCnt reset", int'(localErrCnt), 0);
    check("R1 farErrCnt reset", int'(farErrCnt), 0);

    // R8: unaligned multiframe, corrupt C and zero E bits give nothing
    alignReq = 1'b0;
    runSmf(0, 4'hF, 1'b0, 1'b0, -1, 0);
    runSmf(0, 4'hF, 1'b0, 1'b0, -1, 0);
    // R8: first aligned SMF has no aligned reference
    alignReq = 1'b1;
    runSmf(0, 4'h5, 1'b0, 1'b0, -1, 0);
    // R4 correct C; R5 E1=0, E2=1
    runSmf(0, 4'h0, 1'b0, 1'b1, -1, 0);
    // R2 zeros pattern, R3 C1 flipped
    runSmf(1, 4'h8, 1'b1, 1'b0, -1, 0);
    runSmf(2, 4'h1, 1'b1, 1'b1, -1, 0);
    runSmf(3, 4'h0, 1'b0, 1'b0, -1, 0);
    runSmf(0, 4'h0, 1'b1, 1'b1, -1, 0);
    // R8: mid-SMF drop suppresses this and the following comparison
    runSmf(0, 4'h2, 1'b0, 1'b0, 50, 0);
    runSmf(0, 4'h4, 1'b0, 1'b0, -1, 0);
    runSmf(0, 4'h6, 1'b1, 1'b0, -1, 0);

    // random run with idle gaps (R9) and occasional drops
    for (int n = 0; n < 60; n++)
      runSmf(0, ($urandom % 2) ? 4'($urandom) : 4'h0, 1'($urandom), 1'($urandom),
             ($urandom % 10 == 0) ? int'($urandom % SMFB) : -1, 10);

    // R6 R7 saturation
    for (int n = 0; n < 34; n++) runSmf(0, 4'h3, 1'b0, 1'b0, -1, 0);
    check("R6 localErrCnt saturated", int'(localErrCnt), CMAX);
    check("R7 farErrCnt saturated", int'(farErrCnt), CMAX);

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule